// File: doc/BRIEF.md
# Shadowed SRAM Store/Recall Controller

This block fronts a byte-wide static memory that has a nonvolatile shadow copy behind every word. Its host side uses active-low chip enable, output enable and write enable, plus an active-low store strobe. The block turns these levels into read and write cycles against the working array. It also runs bulk copies between the two arrays: a store copies the working array into the shadow, and a recall copies the shadow back into the working array. Each copy moves one word per clock. While a copy runs, host reads and writes are locked out.

A store can start in three ways. The first is a falling edge on the store strobe. The second is a software sequence of six read addresses. The third is a rising edge on a power-fail input. A flag records whether any write has completed since the last copy. Strobe-started and power-fail stores go ahead only when that flag is set. Software stores always run. During a power-fail store the block pulls the strobe line low, so the rest of the system can see that the block is busy. After reset, a recall runs once before any host access is accepted.

All inputs are registered once before decoding. A read therefore reaches the data outputs one clock after the controls settle. A write is committed when the write cycle ends.

Top module: `nvs_ctrl`

## Requirements
- R1: When chip enable and output enable were sampled low, and write enable and the strobe were sampled high, with no copy running, `dout_en_o` is 1 one clock later and `dout_o` holds the working-array byte at the sampled address.
- R2: While the read controls are held, a change of address alone makes `dout_o` show the new word one clock later.
- R3: `dout_en_o` is 0 one clock after write enable low, strobe low, chip enable high or output enable high is sampled, including when output enable stays low during a write.
- R4: A write cycle (chip enable and write enable low, strobe high) stores the address and data sampled in its last active clock, at the moment chip enable or write enable is seen high.
- R5: The address bus is 17 bits wide. The array holds 2^ARR_AW bytes (256 by default) and is indexed by the low ARR_AW address bits, so higher bits alias.
- R6: Leaving reset starts a recall of every shadow word into the working array. Host reads are refused (`dout_en_o`=0) until it ends. Working-array writes that were never stored are therefore lost over a reset.
- R7: Six read accesses, in order, to 0x00E38, 0x131C7, 0x003E0, 0x03C1F, 0x1303F and 0x00FC0 start a store even when no write is pending.
- R8: A read of any other address in the middle of that sequence, or any write cycle, restarts the sequence tracking. A mismatching address equal to the first entry counts as a new first step.
- R9: A falling strobe edge starts a store when a write is pending.
- R10: A strobe fall or power-fail rise with no pending write starts nothing, and host reads continue at once.
- R11: A rising power-fail input with a write pending starts a store during which `strb_pull_o` is 1. `strb_pull_o` is 0 at all other times.
- R12: While a store or recall runs, reads give `dout_en_o`=0 and write cycles change nothing. Each copy takes 2^ARR_AW clocks.
- R13: A completed write sets the pending flag. Completion of any store or recall clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, starts the boot recall |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| strb_n_i | input | 1 | Store strobe line level, active low |
| pfail_i | input | 1 | Power-fail comparator, 1 = supply below threshold |
| addr_i | input | 17 | Byte address |
| din_i | input | 8 | Write data from the shared bus |
| dout_o | output | 8 | Read data to the shared bus |
| dout_en_o | output | 1 | Drive enable for the shared bus |
| strb_pull_o | output | 1 | Pull the strobe line low (power-fail store busy) |

## Verification
A pending flag that is wrong shows up in two ways. A strobe or power-fail request either locks reads out for 256 clocks when it should not, or lets them through when it should not. The bench samples a read two clocks after each trigger to catch this. A sequence tracker that is off by one step either fires a store after a broken sequence or misses a complete one, and the same read probe shows it. Copy direction and completeness cannot be seen until a reset forces a recall. At that point, previously stored bytes must reappear and unstored writes must vanish. The bench confirms this with reads right after each recall.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  localparam int SEQ_LEN = 6;
  localparam int SEQ_IW  = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STORE,
    ST_RECALL
  } nv_state_e;

  // Unlock sequence for a software store, one entry per step.
  function automatic logic [16:0] seq_addr(input logic [SEQ_IW-1:0] step);
    case (step)
      3'd0:    seq_addr = 17'h00E38;
      3'd1:    seq_addr = 17'h131C7;
      3'd2:    seq_addr = 17'h003E0;
      3'd3:    seq_addr = 17'h03C1F;
      3'd4:    seq_addr = 17'h1303F;
      default: seq_addr = 17'h00FC0;
    endcase
  endfunction

  // The tracker's next step, given the current step and whether the address matched.
  function automatic logic [SEQ_IW-1:0] seq_next(input logic [SEQ_IW-1:0] step,
                                                 input logic hit, input logic first_hit);
    if (hit && step != SEQ_IW'(SEQ_LEN - 1)) seq_next = step + 1'b1;
    else if (!hit && first_hit)              seq_next = SEQ_IW'(1);
    else                                      seq_next = '0;
  endfunction
endpackage

// File: rtl/nvs_bus_front.sv
module nvs_bus_front #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int ARR_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              we_n_i,
  input  logic              strb_n_i,
  input  logic              pfail_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              busy,
  output logic              rd_act,
  output logic              rd_event,
  output logic              wr_start,
  output logic              wr_commit,
  output logic [ARR_AW-1:0] cm_idx,
  output logic [DATA_W-1:0] cm_data,
  output logic [ARR_AW-1:0] rd_idx,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              hw_fall,
  output logic              pf_rise
);
  logic              s_ce, s_oe, s_we, s_strb, s_pf;
  logic [ADDR_W-1:0] s_addr, addr_d;
  logic [DATA_W-1:0] s_din, din_d;
  logic              wr_act, wr_act_d, rd_act_d, strb_d, pf_d;

  // First stage: sample the host levels.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_ce   <= 1'b1;
      s_oe   <= 1'b1;
      s_we   <= 1'b1;
      s_strb <= 1'b1;
      s_pf   <= 1'b0;
      s_addr <= '0;
      s_din  <= '0;
    end else begin
      s_ce   <= ce_n_i;
      s_oe   <= oe_n_i;
      s_we   <= we_n_i;
      s_strb <= strb_n_i;
      s_pf   <= pfail_i;
      s_addr <= addr_i;
      s_din  <= din_i;
    end
  end

  assign wr_act = ~s_ce & ~s_we & s_strb & ~busy;
  assign rd_act = ~s_ce & ~s_oe & s_we & s_strb;

  // Second stage: the previous sample, used to find edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act_d <= 1'b0;
      rd_act_d <= 1'b0;
      strb_d   <= 1'b1;
      pf_d     <= 1'b0;
      addr_d   <= '0;
      din_d    <= '0;
    end else begin
      wr_act_d <= wr_act;
      rd_act_d <= rd_act & ~busy;
      strb_d   <= s_strb;
      pf_d     <= s_pf;
      addr_d   <= s_addr;
      din_d    <= s_din;
    end
  end

  assign wr_start  = wr_act & ~wr_act_d;
  assign wr_commit = wr_act_d & (s_ce | s_we) & ~busy;
  assign rd_event  = rd_act & ~busy & (~rd_act_d | (s_addr != addr_d));
  assign cm_idx    = addr_d[ARR_AW-1:0];
  assign cm_data   = din_d;
  assign rd_idx    = s_addr[ARR_AW-1:0];
  assign cur_addr  = s_addr;
  assign hw_fall   = strb_d & ~s_strb;
  assign pf_rise   = s_pf & ~pf_d;
endmodule

// File: rtl/nvs_seq_track.sv
module nvs_seq_track
  import nvs_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_event,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] addr,
  output logic              sw_go
);
  logic [SEQ_IW-1:0] step;
  logic              hit, first_hit;

  assign hit       = (addr == ADDR_W'(seq_addr(step)));
  assign first_hit = (addr == ADDR_W'(seq_addr('0)));
  assign sw_go     = rd_event & hit & (step == SEQ_IW'(SEQ_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        step <= '0;
    else if (wr_start) step <= '0;
    else if (rd_event) step <= seq_next(step, hit, first_hit);
  end
endmodule

// File: rtl/nvs_sequencer.sv
module nvs_sequencer
  import nvs_pkg::*;
#(
  parameter int ARR_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_go,
  input  logic              hw_fall,
  input  logic              pf_rise,
  input  logic              wr_commit,
  output logic              busy,
  output logic              store_en,
  output logic              recall_en,
  output logic [ARR_AW-1:0] copy_idx,
  output logic              auto_run,
  output logic              dirty
);
  nv_state_e         state;
  logic [ARR_AW-1:0] cnt;
  logic              last;

  assign last      = &cnt;
  assign busy      = (state != ST_IDLE);
  assign store_en  = (state == ST_STORE);
  assign recall_en = (state == ST_RECALL);
  assign copy_idx  = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_RECALL;
      cnt      <= '0;
      auto_run <= 1'b0;
      dirty    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (wr_commit) dirty <= 1'b1;
          cnt <= '0;
          if (sw_go) begin
            state    <= ST_STORE;
            auto_run <= 1'b0;
          end else if (hw_fall && dirty) begin
            state    <= ST_STORE;
            auto_run <= 1'b0;
          end else if (pf_rise && dirty) begin
            state    <= ST_STORE;
            auto_run <= 1'b1;
          end
        end
        default: begin
          cnt <= cnt + 1'b1;
          if (last) begin
            state    <= ST_IDLE;
            auto_run <= 1'b0;
            dirty    <= 1'b0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/nvs_arrays.sv
module nvs_arrays #(
  parameter int ARR_AW = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ARR_AW-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              store_en,
  input  logic              recall_en,
  input  logic [ARR_AW-1:0] copy_idx,
  input  logic [ARR_AW-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  localparam int WORDS = 1 << ARR_AW;

  logic [DATA_W-1:0] work_mem [WORDS];
  logic [DATA_W-1:0] shad_mem [WORDS];

  always_ff @(posedge clk) begin
    if (recall_en)  work_mem[copy_idx] <= shad_mem[copy_idx];
    else if (wr_en) work_mem[wr_idx]   <= wr_data;
    if (store_en)   shad_mem[copy_idx] <= work_mem[copy_idx];
  end

  assign rd_data = work_mem[rd_idx];
endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int ARR_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              we_n_i,
  input  logic              strb_n_i,
  input  logic              pfail_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_en_o,
  output logic              strb_pull_o
);
  logic              busy, rd_act, rd_event, wr_start, wr_commit;
  logic              hw_fall, pf_rise, sw_go;
  logic              store_en, recall_en, auto_run, dirty;
  logic [ARR_AW-1:0] cm_idx, rd_idx, copy_idx;
  logic [DATA_W-1:0] cm_data, rd_data;
  logic [ADDR_W-1:0] cur_addr;

  nvs_bus_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ARR_AW(ARR_AW)) u_front (
    .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n_i), .oe_n_i(oe_n_i), .we_n_i(we_n_i),
    .strb_n_i(strb_n_i), .pfail_i(pfail_i), .addr_i(addr_i), .din_i(din_i),
    .busy(busy), .rd_act(rd_act), .rd_event(rd_event), .wr_start(wr_start),
    .wr_commit(wr_commit), .cm_idx(cm_idx), .cm_data(cm_data), .rd_idx(rd_idx),
    .cur_addr(cur_addr), .hw_fall(hw_fall), .pf_rise(pf_rise)
  );

  nvs_seq_track #(.ADDR_W(ADDR_W)) u_track (
    .clk(clk), .rst_n(rst_n), .rd_event(rd_event), .wr_start(wr_start),
    .addr(cur_addr), .sw_go(sw_go)
  );

  nvs_sequencer #(.ARR_AW(ARR_AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .sw_go(sw_go), .hw_fall(hw_fall), .pf_rise(pf_rise),
    .wr_commit(wr_commit), .busy(busy), .store_en(store_en), .recall_en(recall_en),
    .copy_idx(copy_idx), .auto_run(auto_run), .dirty(dirty)
  );

  nvs_arrays #(.ARR_AW(ARR_AW), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .wr_en(wr_commit), .wr_idx(cm_idx), .wr_data(cm_data),
    .store_en(store_en), .recall_en(recall_en), .copy_idx(copy_idx),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  assign dout_en_o   = rd_act & ~busy;
  assign dout_o      = dout_en_o ? rd_data : '0;
  assign strb_pull_o = store_en & auto_run;
endmodule

// File: rtl/nvs_ctrl_chk.sv
module nvs_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic we_n_i,
  input logic strb_n_i,
  input logic dout_en_o,
  input logic strb_pull_o,
  input logic busy,
  input logic wr_commit,
  input logic sw_go,
  input logic hw_fall,
  input logic dirty
);
  AST_OUT_NEEDS_WE_STRB: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en_o |-> ($past(we_n_i) && $past(strb_n_i))); // R3
  AST_SW_ALWAYS_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_go |=> busy); // R7
  AST_CLEAN_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_fall && !dirty && !busy && !sw_go) |=> !busy); // R10
  AST_PULL_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    strb_pull_o |-> busy); // R11
  AST_COMMIT_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> dirty); // R13
  AST_COPY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !dirty); // R13
endmodule

bind nvs_ctrl nvs_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .we_n_i(we_n_i), .strb_n_i(strb_n_i),
  .dout_en_o(dout_en_o), .strb_pull_o(strb_pull_o), .busy(busy),
  .wr_commit(wr_commit), .sw_go(sw_go), .hw_fall(hw_fall), .dirty(dirty)
);

// File: tb/nvs_ctrl_test.sv
module nvs_ctrl_test;
  localparam int WORDS = 256;
  localparam int COPY  = WORDS + 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, strb_n = 1'b1, pfail = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout_o;
  logic        dout_en_o, strb_pull_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [WORDS];

  always #10 clk = ~clk;

  nvs_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n),
    .strb_n_i(strb_n), .pfail_i(pfail), .addr_i(addr), .din_i(din),
    .dout_o(dout_o), .dout_en_o(dout_en_o), .strb_pull_o(strb_pull_o)
  );

  function automatic logic [16:0] unlock(input int k);
    logic [16:0] t [6] = '{17'h00E38, 17'h131C7, 17'h003E0, 17'h03C1F, 17'h1303F, 17'h00FC0};
    return t[k];
  endfunction

  function automatic int slot(input logic [16:0] a);
    return int'(a) % WORDS;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [16:0] a, output logic en, output logic [7:0] d);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); en = dout_en_o; d = dout_o;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
  endtask

  task automatic run_unlock(input int bad_at);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
      addr = (k == bad_at) ? 17'h00123 : unlock(k);
    end
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic       en;
    logic [7:0] d;
    logic [16:0] a;
    void'($urandom(32'd2417));
    idle(3);
    rst_n = 1'b1;
    // R6: boot recall blocks reads
    rd(17'h00010, en, d);
    check(en == 1'b0, "R6 read refused during boot recall", en, 0);
    check(strb_pull_o == 1'b0, "R11 no pull during recall", strb_pull_o, 0);
    idle(COPY);
    rd(17'h00010, en, d);
    check(en == 1'b1, "R6 read accepted after recall", en, 1);

    // R1 R4 R5: random writes then random reads, upper bits random (aliasing)
    for (int i = 0; i < WORDS; i++) begin
      model[i] = 8'($urandom);
      wr(17'(i) | (17'($urandom % 512) << 8), model[i]);
    end
    for (int i = 0; i < 40; i++) begin
      a = 17'($urandom);
      rd(a, en, d);
      check(en == 1'b1 && d == model[slot(a)], "R1 R4 R5 random read", {en, d}, {1'b1, model[slot(a)]});
    end
    // R5 directed alias
    wr(17'h1FF05, 8'h3C); model[5] = 8'h3C;
    rd(17'h00005, en, d);
    check(d == 8'h3C, "R5 alias of high address", d, 8'h3C);

    // R2: address change alone
    @(negedge clk); addr = 17'h00021; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); check(dout_o == model[33], "R2 first address", dout_o, model[33]);
    addr = 17'h000A7;
    @(negedge clk); check(dout_o == model[167], "R2 follows address", dout_o, model[167]);
    // R3: write enable low with output enable low, then strobe low
    we_n = 1'b0; din = model[167];
    @(negedge clk); check(dout_en_o == 1'b0, "R3 off while write enable low", dout_en_o, 0);
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    idle(2);
    @(negedge clk); addr = 17'h00021; ce_n = 1'b0; oe_n = 1'b0; strb_n = 1'b0;
    @(negedge clk); check(dout_en_o == 1'b0, "R3 off while strobe low", dout_en_o, 0);
    ce_n = 1'b1; oe_n = 1'b1; strb_n = 1'b1;
    idle(COPY); // the strobe fall above started a store (writes pending)

    // R9 R12: strobe store with a write pending
    wr(17'h00040, 8'h99); model[64] = 8'h99;
    @(negedge clk); strb_n = 1'b0;
    @(negedge clk); strb_n = 1'b1;
    rd(17'h00040, en, d);
    check(en == 1'b0, "R9 R12 read refused during strobe store", en, 0);
    check(strb_pull_o == 1'b0, "R11 no pull for strobe store", strb_pull_o, 0);
    wr(17'h0000A, ~model[10]);
    idle(COPY);
    rd(17'h0000A, en, d);
    check(d == model[10], "R12 write during store ignored", d, model[10]);

    // R10 R13: clean strobe and clean power-fail do nothing
    @(negedge clk); strb_n = 1'b0;
    @(negedge clk); strb_n = 1'b1;
    rd(17'h00040, en, d);
    check(en == 1'b1 && d == 8'h99, "R10 R13 clean strobe skipped", {en, d}, {1'b1, 8'h99});
    @(negedge clk); pfail = 1'b1;
    @(negedge clk);
    rd(17'h00040, en, d);
    check(en == 1'b1, "R10 clean power-fail skipped", en, 1);
    check(strb_pull_o == 1'b0, "R11 no pull when skipped", strb_pull_o, 0);
    @(negedge clk); pfail = 1'b0;

    // R7: software sequence runs with nothing pending
    run_unlock(-1);
    rd(17'h00040, en, d);
    check(en == 1'b0, "R7 software store runs when clean", en, 0);
    idle(COPY);
    // R8: broken sequence does not store
    run_unlock(3);
    rd(17'h00040, en, d);
    check(en == 1'b1, "R8 mismatch restarts tracking", en, 1);
    // R8: a write in the middle restarts tracking
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = unlock(k);
    end
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
    wr(17'h00041, 8'h11); model[65] = 8'h11;
    for (int k = 3; k < 6; k++) begin
      @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = unlock(k);
    end
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
    rd(17'h00041, en, d);
    check(en == 1'b1 && d == 8'h11, "R8 write restarts tracking", {en, d}, {1'b1, 8'h11});

    // R11: power-fail store with pending write
    wr(17'h00003, 8'hA5); model[3] = 8'hA5;
    @(negedge clk); pfail = 1'b1;
    idle(2);
    check(strb_pull_o == 1'b1, "R11 pull during power-fail store", strb_pull_o, 1);
    rd(17'h00003, en, d);
    check(en == 1'b0, "R11 R12 reads refused in power-fail store", en, 0);
    idle(COPY);
    check(strb_pull_o == 1'b0, "R11 pull released", strb_pull_o, 0);
    pfail = 1'b0;

    // R6: stored contents return after reset
    do_reset();
    idle(COPY);
    for (int i = 0; i < 12; i++) begin
      a = 17'($urandom);
      rd(a, en, d);
      check(en == 1'b1 && d == model[slot(a)], "R6 stored data recalled", {en, d}, {1'b1, model[slot(a)]});
    end
    // R6 R13: unstored write lost over reset
    wr(17'h00003, 8'h5A);
    do_reset();
    idle(COPY);
    rd(17'h00003, en, d);
    check(d == 8'hA5, "R6 R13 unstored write lost", d, 8'hA5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule